// File: doc/BRIEF.md
# Link Sequence Checker

This block watches the header stream of one receive link. Each header carries a sequence number that should be one more than the previous one. The block keeps its own expected number and compares every header against it. A mismatch raises a one-cycle error pulse for downstream logic and a sticky error flag. The expected number steps forward on every header, whether or not the header matched. The received value is never taken over in normal operation.

A run of consecutive mismatches is counted. When the run reaches three, the link is in an excessive-error condition. If automatic removal is enabled, that condition or an out-of-frame indication takes the link out of service. Software brings a removed link back with the rejoin control. The first header after a rejoin sets the expected number, and the link is in service again from that header on.

Top module: `link_seq_checker`

## Requirements
- R1: After reset, `link_good_o`, `seq_err_o` and `err_pulse_o` are low, and the expected sequence number is 0.
- R2: A header whose sequence number differs from the expected value raises `err_pulse_o` for exactly the cycle after the header cycle. A matching header raises no pulse.
- R3: `seq_err_o` is set by any mismatch and stays high until `err_clr_i` is asserted. A mismatch in the same cycle as `err_clr_i` wins, and the flag stays set.
- R4: The expected number is 8 bits wide. It increments by one modulo 256 after every checked header, whether matched or not (255 is followed by 0). It is never loaded from a mismatched header.
- R5: With `auto_remove_i` high, a third consecutive mismatch drops `link_good_o` two cycles after that header. A matching header resets the run, so two mismatches, then a match, then a mismatch do not remove the link.
- R6: With `auto_remove_i` low, the link stays good through any number of consecutive mismatches.
- R7: With `auto_remove_i` high, `oof_i` high on an in-service link drops `link_good_o` on the next cycle. With `auto_remove_i` low, `oof_i` has no effect.
- R8: `rejoin_i` on an out-of-service link makes the next header load the expected number with its own value plus one. That header raises no error and brings `link_good_o` high in the following cycle. Later headers are checked strictly.
- R9: `rejoin_i` while the link is in service has no effect on `link_good_o` or on checking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | One-cycle strobe: a header is present |
| hdr_seq_i | input | 8 | Sequence number in the header |
| oof_i | input | 1 | Out-of-frame indication |
| auto_remove_i | input | 1 | Enables automatic removal from service |
| rejoin_i | input | 1 | Request to bring a removed link back |
| err_clr_i | input | 1 | Write-one-to-clear for the sticky error flag |
| seq_err_o | output | 1 | Sticky sequence-error flag |
| err_pulse_o | output | 1 | One-cycle mismatch pulse |
| link_good_o | output | 1 | Link is in service |

## Verification
If the expected counter is wrong, even by one step, the next header shows a pulse one cycle later. The pulse is either missing or spurious, so a counter that resyncs or skips shows up within one header. If the run counter is wrong, removal happens too early, too late or never. This shows on `link_good_o` two cycles after the third bad header, and the bench samples exactly at that point. A wrong state register shows through rejoin: the link rejoins without a header, a header after rejoin still raises an error, or a rejoin while in service drops the link.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;
  typedef enum logic [1:0] {
    LINK_DOWN = 2'd0,
    LINK_SYNC = 2'd1,
    LINK_UP   = 2'd2
  } link_st_e;
endpackage

// File: rtl/seq_tracker.sv
module seq_tracker #(
  parameter int SEQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_valid_i,
  input  logic [SEQ_W-1:0] hdr_seq_i,
  input  logic             resync_i,
  output logic             mismatch_o
);
  logic [SEQ_W-1:0] exp_q;

  assign mismatch_o = hdr_valid_i && !resync_i && (hdr_seq_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      exp_q <= '0;
    else if (hdr_valid_i && resync_i) exp_q <= hdr_seq_i + SEQ_W'(1);
    else if (hdr_valid_i)             exp_q <= exp_q + SEQ_W'(1);
  end

  // R4
  exp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && !resync_i |=> exp_q == $past(exp_q) + SEQ_W'(1));
  // R8
  exp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && resync_i |=> exp_q == $past(hdr_seq_i) + SEQ_W'(1));
endmodule

// File: rtl/err_run_counter.sv
module err_run_counter #(
  parameter int MAX_RUN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hdr_valid_i,
  input  logic mismatch_i,
  input  logic clear_i,
  output logic excess_o
);
  localparam int CNT_W = $clog2(MAX_RUN + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (hdr_valid_i) begin
      if (!mismatch_i)                  cnt_q <= '0;
      else if (cnt_q != CNT_W'(MAX_RUN)) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign excess_o = (cnt_q == CNT_W'(MAX_RUN));

  // R5
  run_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && !mismatch_i |=> !excess_o);
  // R5
  run_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excess_o && !clear_i |=> excess_o || $past(hdr_valid_i && !mismatch_i));
endmodule

// File: rtl/link_state.sv
module link_state
  import link_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hdr_valid_i,
  input  logic rejoin_i,
  input  logic auto_remove_i,
  input  logic oof_i,
  input  logic excess_i,
  output logic resync_o,
  output logic link_good_o
);
  link_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LINK_DOWN: if (rejoin_i) st_d = LINK_SYNC;
      LINK_SYNC: begin
        if (auto_remove_i && oof_i) st_d = LINK_DOWN;
        else if (hdr_valid_i)       st_d = LINK_UP;
      end
      LINK_UP:   if (auto_remove_i && (oof_i || excess_i)) st_d = LINK_DOWN;
      default:   st_d = LINK_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LINK_DOWN;
    else         st_q <= st_d;
  end

  assign resync_o    = (st_q == LINK_SYNC);
  assign link_good_o = (st_q == LINK_UP);

  // R6
  keep_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_good_o && !auto_remove_i |=> link_good_o);
  // R7
  oof_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_good_o && auto_remove_i && oof_i |=> !link_good_o);
  // R8
  no_silent_join_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_good_o && !(resync_o && hdr_valid_i) |=> !link_good_o);
endmodule

// File: rtl/link_seq_checker.sv
module link_seq_checker #(
  parameter int SEQ_W   = 8,
  parameter int MAX_RUN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_valid_i,
  input  logic [SEQ_W-1:0] hdr_seq_i,
  input  logic             oof_i,
  input  logic             auto_remove_i,
  input  logic             rejoin_i,
  input  logic             err_clr_i,
  output logic             seq_err_o,
  output logic             err_pulse_o,
  output logic             link_good_o
);
  logic mismatch, resync, excess;
  logic pulse_q, sticky_q;

  seq_tracker #(.SEQ_W(SEQ_W)) u_track (
    .clk_i, .rst_ni, .hdr_valid_i, .hdr_seq_i,
    .resync_i(resync), .mismatch_o(mismatch)
  );

  err_run_counter #(.MAX_RUN(MAX_RUN)) u_run (
    .clk_i, .rst_ni, .hdr_valid_i, .mismatch_i(mismatch),
    .clear_i(hdr_valid_i && resync), .excess_o(excess)
  );

  link_state u_state (
    .clk_i, .rst_ni, .hdr_valid_i, .rejoin_i, .auto_remove_i, .oof_i,
    .excess_i(excess), .resync_o(resync), .link_good_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      pulse_q <= mismatch;
      if (mismatch)       sticky_q <= 1'b1;
      else if (err_clr_i) sticky_q <= 1'b0;
    end
  end

  assign err_pulse_o = pulse_q;
  assign seq_err_o   = sticky_q;

  // R2
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> $past(hdr_valid_i));
  // R3
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o && !err_clr_i |=> seq_err_o);
  // R3
  sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> seq_err_o);
endmodule

// File: tb/link_seq_checker_tb.sv
module link_seq_checker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0, oof = 1'b0, auto_rm = 1'b0, rejoin = 1'b0, err_clr = 1'b0;
  logic [7:0] hdr_seq = '0;
  logic seq_err, err_pulse, link_good;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_seq = '0;

  always #2 clk = ~clk;

  link_seq_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hdr_valid_i(hdr_valid), .hdr_seq_i(hdr_seq),
    .oof_i(oof), .auto_remove_i(auto_rm), .rejoin_i(rejoin), .err_clr_i(err_clr),
    .seq_err_o(seq_err), .err_pulse_o(err_pulse), .link_good_o(link_good)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // drive a header for one cycle; returns at the negedge after the sampling edge
  task automatic send_hdr(logic [7:0] s);
    hdr_seq = s; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    exp_seq = exp_seq + 8'd1;
  endtask

  task automatic pulse_rejoin();
    rejoin = 1'b1; @(negedge clk); rejoin = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 link_good", link_good, 1'b0);
    check("R1 seq_err", seq_err, 1'b0);
    check("R1 err_pulse", err_pulse, 1'b0);
    send_hdr(8'd0);
    check("R1 expected starts at 0", err_pulse, 1'b0);
  endtask

  task automatic t_mismatch();
    send_hdr(8'd5);
    check("R2 pulse on mismatch", err_pulse, 1'b1);
    check("R3 sticky set", seq_err, 1'b1);
    @(negedge clk);
    check("R2 pulse one cycle", err_pulse, 1'b0);
    check("R3 sticky holds", seq_err, 1'b1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    check("R3 cleared", seq_err, 1'b0);
  endtask

  task automatic t_rejoin_wrap();
    pulse_rejoin();
    check("R8 not good before header", link_good, 1'b0);
    send_hdr(8'd254); exp_seq = 8'd255;
    check("R8 no error on resync header", err_pulse, 1'b0);
    check("R8 good after header", link_good, 1'b1);
    send_hdr(8'd255);
    check("R4 255 ok", err_pulse, 1'b0);
    send_hdr(8'd0);
    check("R4 wrap to 0", err_pulse, 1'b0);
    pulse_rejoin();
    check("R9 rejoin in service", link_good, 1'b1);
    send_hdr(exp_seq);
    check("R9 checking unchanged", err_pulse, 1'b0);
    check("R9 still good", link_good, 1'b1);
  endtask

  task automatic t_no_resync();
    send_hdr(8'd50);
    check("R4 mismatch", err_pulse, 1'b1);
    send_hdr(exp_seq);
    check("R4 no load from bad header", err_pulse, 1'b0);
  endtask

  task automatic t_no_auto();
    auto_rm = 1'b0;
    for (int i = 0; i < 4; i++) send_hdr(8'd99);
    repeat (2) @(negedge clk);
    check("R6 stays good", link_good, 1'b1);
    oof = 1'b1; @(negedge clk); @(negedge clk); oof = 1'b0;
    check("R7 oof ignored without auto", link_good, 1'b1);
    send_hdr(exp_seq);
  endtask

  task automatic t_auto_remove();
    auto_rm = 1'b1;
    send_hdr(8'd99); send_hdr(8'd99);
    send_hdr(exp_seq);
    send_hdr(8'd99);
    @(negedge clk); @(negedge clk);
    check("R5 match resets run", link_good, 1'b1);
    send_hdr(8'd98); send_hdr(8'd98);
    check("R5 not yet removed", link_good, 1'b1);
    @(negedge clk);
    check("R5 removed two cycles after third", link_good, 1'b0);
  endtask

  task automatic t_rejoin_after_remove();
    pulse_rejoin();
    send_hdr(8'd200); exp_seq = 8'd201;
    check("R8 good again", link_good, 1'b1);
    check("R8 resync no pulse", err_pulse, 1'b0);
    send_hdr(8'd200);
    check("R8 strict after resync", err_pulse, 1'b1);
  endtask

  task automatic t_oof();
    auto_rm = 1'b1;
    oof = 1'b1; @(negedge clk); oof = 1'b0;
    check("R7 oof removes", link_good, 1'b0);
  endtask

  task automatic t_clr_priority();
    err_clr = 1'b1; send_hdr(8'd7); err_clr = 1'b0;
    check("R3 set wins over clear", seq_err, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mismatch();
    t_rejoin_wrap();
    t_no_resync();
    t_no_auto();
    t_auto_remove();
    t_rejoin_after_remove();
    t_oof();
    t_clr_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule